// File: doc/BRIEF.md
# Programming-Mode Entry Sequencer

This block is the host side of a serial programming link. When asked to start, it produces the pin-level waveform that unlocks a target's program/verify mode. First it gives a brief high pulse on the enable line and then drives that line low. After a guard interval it shifts a 32-bit unlock key onto the data line, most significant bit first, with one serial clock per bit. A short delay after the last bit, it raises the enable line and keeps it high. Once a settle interval has passed, it reports that the target is ready for commands.

Every interval is a parameter counted in system clock cycles: the enable pulse width, the guard time, the serial clock half-period, the delay before enable rises and the settle time. Handshakes are kept simple. A one-cycle start request begins the sequence, and busy stays high while the sequence runs. Ready holds, with enable high, until an abort or a new start. An abort at any point returns every line low.

Top module: `pmode_entry_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy_o, ready_o, en_o, sclk_o and sdat_o are all 0.
- R2: A start_i sampled high while idle (no abort) makes busy_o and en_o 1 from the next cycle, for exactly PULSE_CYC cycles, with sclk_o and sdat_o 0.
- R3: After the enable pulse, en_o, sclk_o and sdat_o stay 0 for exactly GUARD_CYC cycles before the first key bit.
- R4: The key (default 0x4D434851) is sent with bit KEY_W-1 first. Each bit takes 2*HALF_CYC cycles: HALF_CYC cycles with sclk_o 0 and then HALF_CYC cycles with sclk_o 1. sdat_o holds the bit value for the whole bit period, so it changes only while sclk_o goes or stays low. Exactly KEY_W rising edges of sclk_o occur per sequence.
- R5: After the high half of the last bit, all three lines stay 0 for exactly RISE_CYC cycles. Then en_o rises.
- R6: en_o stays 1 with sclk_o and sdat_o 0 for SETTLE_CYC cycles, with busy_o still 1. In the following cycle busy_o falls and ready_o rises.
- R7: ready_o and en_o remain 1 and sclk_o and sdat_o remain 0 for as long as neither start_i nor abort_i is sampled high.
- R8: busy_o is 1 from the cycle after an accepted start until the cycle ready_o rises, and never together with ready_o. A start_i sampled high while busy_o is 1 has no effect on any output.
- R9: An abort_i sampled high in any state makes all five outputs 0 in the next cycle. Abort wins over a start sampled in the same cycle.
- R10: A start_i sampled high while ready_o is 1 restarts the full sequence, with the same timing as from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled each cycle |
| abort_i | input | 1 | Abort request, returns all lines low |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target unlocked, enable held high |
| en_o | output | 1 | Target enable line |
| sclk_o | output | 1 | Serial clock to target |
| sdat_o | output | 1 | Serial data to target |

## Verification
A clean run is compared cycle by cycle against an arithmetic model of the waveform. This pins down each interval length and the bit order and phase of the key. A restart issued from ready must reproduce the same waveform, which separates restart from a sticky ready. A run with start pulses sprinkled through the busy period must also match the model exactly, which catches a start that is wrongly accepted mid-sequence. An abort is then swept across every cycle offset of the sequence and into ready, and an abort coinciding with start is tried from ready, to show that every state returns all lines low and that abort takes priority.

// File: rtl/pmode_entry_pkg.sv
package pmode_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GUARD,
        ST_SHIFT,
        ST_RISE,
        ST_SETTLE,
        ST_READY
    } pm_state_e;

    localparam logic [31:0] UNLOCK_KEY = 32'h4D434851;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pmode_interval_timer.sv
module pmode_interval_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pmode_key_shifter.sv
module pmode_key_shifter
    import pmode_entry_pkg::*;
#(
    parameter int          KEY_W    = 32,
    parameter logic [KEY_W-1:0] KEY = UNLOCK_KEY,
    parameter int          HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    output logic sclk_o,
    output logic sdat_o,
    output logic done_o
);
    localparam int IW  = width_for(KEY_W);
    localparam int HCW = width_for(HALF_CYC);
    localparam logic [HCW-1:0] HALF_LAST = HCW'(HALF_CYC - 1);
    localparam logic [IW-1:0]  IDX_TOP   = IW'(KEY_W - 1);

    logic [IW-1:0]  idx_q;
    logic [HCW-1:0] hcnt_q;
    logic           phase_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            idx_q   <= IDX_TOP;
            hcnt_q  <= '0;
            phase_q <= 1'b0;
        end else if (hcnt_q == HALF_LAST) begin
            hcnt_q  <= '0;
            phase_q <= ~phase_q;
            if (phase_q) begin
                idx_q <= idx_q - 1'b1;
            end
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign sclk_o = active_i & phase_q;
    assign sdat_o = active_i & KEY[idx_q];
    assign done_o = active_i & phase_q & (hcnt_q == HALF_LAST) & (idx_q == '0);
endmodule

// File: rtl/pmode_entry_seq.sv
module pmode_entry_seq
    import pmode_entry_pkg::*;
#(
    parameter int               KEY_W      = 32,
    parameter logic [KEY_W-1:0] KEY        = UNLOCK_KEY,
    parameter int               PULSE_CYC  = 4,
    parameter int               GUARD_CYC  = 8,
    parameter int               HALF_CYC   = 4,
    parameter int               RISE_CYC   = 2,
    parameter int               SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic abort_i,
    output logic busy_o,
    output logic ready_o,
    output logic en_o,
    output logic sclk_o,
    output logic sdat_o
);
    localparam int unsigned MAX_LEN = max_of(max_of(PULSE_CYC, GUARD_CYC),
                                             max_of(RISE_CYC, SETTLE_CYC));
    localparam int TW = width_for(MAX_LEN);
    localparam logic [TW-1:0] LD_PULSE  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_GUARD  = TW'(GUARD_CYC - 1);
    localparam logic [TW-1:0] LD_RISE   = TW'(RISE_CYC - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);

    pm_state_e     st_q, st_d;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_done;
    logic          shift_active;
    logic          shift_done;
    logic          shift_clk;
    logic          shift_dat;

    pmode_interval_timer #(.W(TW)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (t_val),
        .done_o     (t_done)
    );

    assign shift_active = (st_q == ST_SHIFT);

    pmode_key_shifter #(
        .KEY_W    (KEY_W),
        .KEY      (KEY),
        .HALF_CYC (HALF_CYC)
    ) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .active_i (shift_active),
        .sclk_o   (shift_clk),
        .sdat_o   (shift_dat),
        .done_o   (shift_done)
    );

    always_comb begin
        st_d   = st_q;
        t_load = 1'b0;
        t_val  = '0;
        case (st_q)
            ST_IDLE, ST_READY: begin
                if (start_i) begin
                    st_d   = ST_PULSE;
                    t_load = 1'b1;
                    t_val  = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (t_done) begin
                    st_d   = ST_GUARD;
                    t_load = 1'b1;
                    t_val  = LD_GUARD;
                end
            end
            ST_GUARD: begin
                if (t_done) st_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (shift_done) begin
                    st_d   = ST_RISE;
                    t_load = 1'b1;
                    t_val  = LD_RISE;
                end
            end
            ST_RISE: begin
                if (t_done) begin
                    st_d   = ST_SETTLE;
                    t_load = 1'b1;
                    t_val  = LD_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (t_done) st_d = ST_READY;
            end
            default: st_d = ST_IDLE;
        endcase
        if (abort_i) begin
            st_d   = ST_IDLE;
            t_load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign en_o    = (st_q == ST_PULSE) || (st_q == ST_SETTLE) || (st_q == ST_READY);
    assign busy_o  = (st_q != ST_IDLE) && (st_q != ST_READY);
    assign ready_o = (st_q == ST_READY);
    assign sclk_o  = shift_clk;
    assign sdat_o  = shift_dat;
endmodule

// File: rtl/pmode_entry_chk.sv
module pmode_entry_chk #(
    parameter int KEY_W = 32
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic abort_i,
    input logic busy_o,
    input logic ready_o,
    input logic en_o,
    input logic sclk_o,
    input logic sdat_o
);
    logic        sclk_q;
    logic [15:0] rises_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            rises_q <= '0;
        end else begin
            sclk_q <= sclk_o;
            if (abort_i || ready_o) rises_q <= '0;
            else if (sclk_o && !sclk_q) rises_q <= rises_q + 1'b1;
        end
    end

    a_r8_busy_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && ready_o));

    a_r4_clock_only_in_shift: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> (busy_o && !en_o));

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && sclk_q) |-> $stable(sdat_o));

    a_r4_edge_count: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (rises_q == 16'(KEY_W)));

    a_r7_ready_holds_enable: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (en_o && !sclk_o && !sdat_o));

    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i && !abort_i) |=> ready_o);

    a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!busy_o && !ready_o && !en_o && !sclk_o && !sdat_o));

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !abort_i) |=> (busy_o && en_o && !ready_o));

    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !abort_i && !sclk_o && en_o && $past(en_o)) |=> busy_o);
endmodule

bind pmode_entry_seq pmode_entry_chk #(.KEY_W(KEY_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .abort_i (abort_i),
    .busy_o  (busy_o),
    .ready_o (ready_o),
    .en_o    (en_o),
    .sclk_o  (sclk_o),
    .sdat_o  (sdat_o)
);

// File: tb/pmode_entry_seq_tb.sv
module pmode_entry_seq_tb_top;
    localparam int          KW  = 32;
    localparam logic [31:0] KEY = 32'h4D434851;
    localparam int P = 2, G = 3, H = 2, R = 1, S = 4;
    localparam int SH0 = P + G;
    localparam int RS0 = SH0 + KW * 2 * H;
    localparam int ST0 = RS0 + R;
    localparam int TB  = ST0 + S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic abort_i = 1'b0;
    logic busy_o, ready_o, en_o, sclk_o, sdat_o;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pmode_entry_seq #(
        .KEY_W(KW), .KEY(KEY), .PULSE_CYC(P), .GUARD_CYC(G),
        .HALF_CYC(H), .RISE_CYC(R), .SETTLE_CYC(S)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .busy_o(busy_o), .ready_o(ready_o), .en_o(en_o),
        .sclk_o(sclk_o), .sdat_o(sdat_o)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk_all_low(input string tag);
        chk(tag, "busy", busy_o, 1'b0);
        chk(tag, "ready", ready_o, 1'b0);
        chk(tag, "en", en_o, 1'b0);
        chk(tag, "sclk", sclk_o, 1'b0);
        chk(tag, "sdat", sdat_o, 1'b0);
    endtask

    // expected outputs at cycle t after an accepted start
    task automatic chk_cycle(input int t, input string override_tag);
        logic e_busy, e_ready, e_en, e_sclk, e_sdat;
        string tag;
        e_busy = 1'b1; e_ready = 1'b0; e_en = 1'b0; e_sclk = 1'b0; e_sdat = 1'b0;
        if (t < P) begin
            tag = "R2"; e_en = 1'b1;
        end else if (t < SH0) begin
            tag = "R3";
        end else if (t < RS0) begin
            int u = t - SH0;
            int b = u / (2 * H);
            tag = "R4";
            e_sclk = ((u % (2 * H)) >= H);
            e_sdat = KEY[KW - 1 - b];
        end else if (t < ST0) begin
            tag = "R5";
        end else if (t < TB) begin
            tag = "R6"; e_en = 1'b1;
        end else begin
            tag = "R7"; e_busy = 1'b0; e_ready = 1'b1; e_en = 1'b1;
        end
        if (override_tag != "") tag = {override_tag, "/", tag};
        chk(tag, $sformatf("busy t=%0d", t), busy_o, e_busy);
        chk(tag, $sformatf("ready t=%0d", t), ready_o, e_ready);
        chk(tag, $sformatf("en t=%0d", t), en_o, e_en);
        chk(tag, $sformatf("sclk t=%0d", t), sclk_o, e_sclk);
        chk(tag, $sformatf("sdat t=%0d", t), sdat_o, e_sdat);
    endtask

    // called at a negedge; start is seen at the next posedge
    task automatic run_seq(input bit inject, input int n, input string tag);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t < n; t++) begin
            chk_cycle(t, tag);
            start_i = (inject && t < TB - 1 && (t % 7) == 3);
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk_all_low("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_all_low("R1");

        run_seq(1'b0, TB + 20, "");
        run_seq(1'b0, TB + 5, "R10");
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk_all_low("R9");
        run_seq(1'b1, TB + 3, "R8");

        // abort together with start from ready: abort wins
        abort_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        start_i = 1'b0;
        chk_all_low("R9");
        @(negedge clk);
        chk_all_low("R9");

        // abort at every offset of the sequence and into ready
        for (int k = 0; k <= TB + 2; k++) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (k) @(negedge clk);
            abort_i = 1'b1;
            @(negedge clk);
            abort_i = 1'b0;
            chk_all_low($sformatf("R9 k=%0d", k));
            @(negedge clk);
        end

        // abort together with start while idle
        abort_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        start_i = 1'b0;
        chk_all_low("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule